// File: doc/BRIEF.md
# Strap-Addressed SMBus Configuration Slave

This block lets a host on a two-wire SMBus read and write a small bank of 8-bit configuration registers. The slave answers at a 7-bit address made of a fixed base of 0x58 plus a 4-bit strap, so up to sixteen copies can share one bus at addresses 0x58 to 0x67. SCL and SDA are brought in through two-flop synchronizers. START and STOP are found on the synchronized samples. The open-drain SDA pad is modelled as a single pull-low enable.

A mode input selects between pin control and register control. In pin mode every register is held at its reset default, and the equalization and de-emphasis outputs follow their pin inputs. In register mode those outputs come from the registers at once. The rate, receiver-detect and idle-threshold outputs follow the shared pins unless the matching override bit is set, in which case each channel's register field is used. One control bit restores all defaults and then clears itself. A second control bit gives a one-cycle reset pulse to an external master state machine.

Top module: `smb_cfg_slave`

## Requirements
- R1: The slave acknowledges an address byte only when its upper seven bits equal 0x58 + strap_i (strap 0000 gives write byte 0xB0). It acknowledges by holding sda_oe_o high through the ninth SCL pulse.
- R2: START is SDA falling while SCL is high, and STOP is SDA rising while SCL is high. sda_oe_o changes only while the synchronized SCL is low.
- R3: After a STOP, a START is ignored until SCL and SDA have both been high for TBUF_CYC clock cycles. A repeated START inside a transfer is always accepted.
- R4: A write is address byte with R/W=0, register pointer, then one data byte. Each of the three bytes is acknowledged, and the pointed register takes the data through its write mask.
- R5: A read is address byte with R/W=0, pointer, repeated START, address byte with R/W=1, then one data byte sent MSB first that the master ends with a NACK. Unmapped addresses read 0x00.
- R6: While mode_i is 0, every register is held at its default, writes have no effect, and eq_o/dem_o follow eq_pin_i/dem_pin_i. While mode_i is 1, eq_o/dem_o come from the registers in the same cycle.
- R7: Override register 0x08 routes the outputs. Bit 2 selects the rate_o source, bit 3 the rxdet_o source and bit 6 the idle_o source. Each bit picks the per-channel register field when it is 1 and the shared pin when it is 0.
- R8: Writing 1 to bit 6 of register 0x07 restores every register to its default, and the bit reads back 0. Writing 1 to bit 5 drives mst_rst_o high for exactly one clock cycle, after which the bit clears.
- R9: Only bits in a register's write mask change; all other bits keep their defaults. The map is given as address: default/mask. Channel c uses base 0x0E+7c, with these offsets: +0 receiver detect 0x00/0x0C (field bits 3:2), +1 equalization 0x2F/0xFF, +2 rate 0xED/0xC0 (field bit 6), +3 de-emphasis 0x02/0x07 (field bits 2:0) and +4 idle threshold 0x00/0x0F (field bits 3:0). The global registers are 0x07 control 0x01/0x60, 0x08 override 0x00/0x4C and 0x51 identity 0x77/0x00 (read-only).
- R10: After an address byte that does not match, the slave drives no ACK on any byte until the next START, and the register bank is unchanged.
- R11: After rst_ni is released, every register reads its default.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | SMBus clock line level |
| sda_i | input | 1 | SMBus data line level |
| sda_oe_o | output | 1 | Pull SDA low when 1 |
| strap_i | input | 4 | Address strap added to base 0x58 |
| mode_i | input | 1 | 0 = pin control, 1 = register control |
| eq_pin_i | input | NUM_CH x 8 | Equalization pin setting per channel |
| dem_pin_i | input | NUM_CH x 3 | De-emphasis pin setting per channel |
| rate_pin_i | input | 1 | Shared rate pin |
| rxdet_pin_i | input | 2 | Shared receiver-detect pin |
| idle_pin_i | input | 4 | Shared idle-threshold pin |
| eq_o | output | NUM_CH x 8 | Active equalization setting |
| dem_o | output | NUM_CH x 3 | Active de-emphasis setting |
| rate_o | output | NUM_CH | Active rate select |
| rxdet_o | output | NUM_CH x 2 | Active receiver-detect mode |
| idle_o | output | NUM_CH x 4 | Active idle thresholds |
| mst_rst_o | output | 1 | One-cycle master state machine reset |

## Verification
The bench sweeps all sixteen strap values, sending both the owning address and its neighbour. A decoder that dropped the base offset or a strap bit would ACK the wrong one. Every mapped register is written with all-ones, all-zeros and a mixed pattern and then read back. This catches a mask that lets read-only bits change or loses writable ones. A START sent only a few cycles after a STOP must be ignored, and bytes that follow a mismatched address must get no ACK. A slave that rejoined the bus early would acknowledge these or change state. Further tests change the mode while register values differ from the pins, toggle each override bit, and count how many cycles the master-reset pulse lasts. These catch writes leaking through in pin mode, a swapped override bit, and a self-clearing bit that sticks.

// File: rtl/smb_cfg_pkg.sv
package smb_cfg_pkg;
  localparam logic [6:0] ADDR_BASE = 7'h58;
  localparam logic [7:0] A_CTRL    = 8'h07;
  localparam logic [7:0] A_OVR     = 8'h08;
  localparam logic [7:0] A_INFO    = 8'h51;
  localparam logic [7:0] A_CH0     = 8'h0E;
  localparam int CH_STRIDE = 7;
  localparam int CH_FIELDS = 5;
  localparam int GLB_SLOTS = 3;
  // field slots inside a channel block
  localparam int F_RXD  = 0;
  localparam int F_EQ   = 1;
  localparam int F_RATE = 2;
  localparam int F_DEM  = 3;
  localparam int F_IDLE = 4;
  // control / override bit positions
  localparam int CTRL_RST  = 6;
  localparam int CTRL_MST  = 5;
  localparam int OVR_RATE  = 2;
  localparam int OVR_RXD   = 3;
  localparam int OVR_IDLE  = 6;

  typedef enum logic [3:0] {
    S_IDLE, S_ADDR, S_AACK, S_PTR, S_PACK, S_WDAT, S_WACK, S_RDAT, S_MACK, S_IGN
  } smb_state_e;

  function automatic logic [7:0] slot_addr(input int s);
    if (s == 0) return A_CTRL;
    if (s == 1) return A_OVR;
    if (s == 2) return A_INFO;
    return 8'(int'(A_CH0) + CH_STRIDE * ((s - GLB_SLOTS) / CH_FIELDS) + (s - GLB_SLOTS) % CH_FIELDS);
  endfunction

  function automatic logic [7:0] slot_def(input int s);
    if (s == 0) return 8'h01;
    if (s == 1) return 8'h00;
    if (s == 2) return 8'h77;
    case ((s - GLB_SLOTS) % CH_FIELDS)
      F_EQ:    return 8'h2F;
      F_RATE:  return 8'hED;
      F_DEM:   return 8'h02;
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic [7:0] slot_mask(input int s);
    if (s == 0) return 8'h60;
    if (s == 1) return 8'h4C;
    if (s == 2) return 8'h00;
    case ((s - GLB_SLOTS) % CH_FIELDS)
      F_RXD:   return 8'h0C;
      F_EQ:    return 8'hFF;
      F_RATE:  return 8'hC0;
      F_DEM:   return 8'h07;
      default: return 8'h0F;
    endcase
  endfunction
endpackage

// File: rtl/smb_bus_mon.sv
module smb_bus_mon #(
  parameter int TBUF_CYC = 50
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s_o,
  output logic sda_s_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o,
  output logic free_o
);
  localparam int CW = $clog2(TBUF_CYC + 1);

  logic [1:0]    scl_sync, sda_sync;
  logic          scl_q, sda_q;
  logic [CW-1:0] hi_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_sync <= 2'b11;
      sda_sync <= 2'b11;
      scl_q    <= 1'b1;
      sda_q    <= 1'b1;
    end else begin
      scl_sync <= {scl_sync[0], scl_i};
      sda_sync <= {sda_sync[0], sda_i};
      scl_q    <= scl_sync[1];
      sda_q    <= sda_sync[1];
    end
  end

  assign scl_s_o    = scl_sync[1];
  assign sda_s_o    = sda_sync[1];
  assign scl_rise_o = scl_s_o & ~scl_q;
  assign scl_fall_o = ~scl_s_o & scl_q;
  assign start_o    = scl_s_o & scl_q & sda_q & ~sda_s_o;
  assign stop_o     = scl_s_o & scl_q & ~sda_q & sda_s_o;

  // bus-free timer: both lines high for TBUF_CYC cycles after a STOP
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_cnt <= '0;
      free_o <= 1'b1;
    end else if (stop_o) begin
      hi_cnt <= '0;
      free_o <= 1'b0;
    end else if (!(scl_s_o && sda_s_o)) begin
      hi_cnt <= '0;
    end else if (!free_o) begin
      if (hi_cnt == CW'(TBUF_CYC - 1)) free_o <= 1'b1;
      else                             hi_cnt <= hi_cnt + 1'b1;
    end
  end

  AST_FREE_AFTER_STOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_o |=> !free_o); // R3
  AST_FREE_NEEDS_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(free_o) |-> $past(scl_s_o && sda_s_o)); // R3
endmodule

// File: rtl/smb_proto.sv
module smb_proto
  import smb_cfg_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       scl_s_i,
  input  logic       sda_s_i,
  input  logic       scl_rise_i,
  input  logic       scl_fall_i,
  input  logic       start_i,
  input  logic       stop_i,
  input  logic       free_i,
  input  logic [3:0] strap_i,
  input  logic [7:0] rd_data_i,
  output logic       sda_oe_o,
  output logic       wr_en_o,
  output logic [7:0] ptr_o,
  output logic [7:0] wr_data_o
);
  smb_state_e state;
  logic [7:0] sh;
  logic [3:0] bitcnt;
  logic       rd_mode;
  logic [6:0] own_addr;

  assign own_addr  = 7'(ADDR_BASE + 7'(strap_i));
  assign wr_data_o = sh;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state    <= S_IDLE;
      sh       <= '0;
      bitcnt   <= '0;
      rd_mode  <= 1'b0;
      ptr_o    <= '0;
      sda_oe_o <= 1'b0;
      wr_en_o  <= 1'b0;
    end else begin
      wr_en_o <= 1'b0;
      if (start_i && (state != S_IDLE || free_i)) begin
        state    <= S_ADDR;
        bitcnt   <= '0;
        sda_oe_o <= 1'b0;
      end else if (stop_i) begin
        state    <= S_IDLE;
        sda_oe_o <= 1'b0;
      end else begin
        case (state)
          S_ADDR, S_PTR, S_WDAT: begin
            if (scl_rise_i) begin
              sh     <= {sh[6:0], sda_s_i};
              bitcnt <= bitcnt + 1'b1;
            end else if (scl_fall_i && bitcnt == 4'd8) begin
              if (state == S_ADDR) begin
                if (sh[7:1] == own_addr) begin
                  state    <= S_AACK;
                  rd_mode  <= sh[0];
                  sda_oe_o <= 1'b1;
                end else begin
                  state <= S_IGN;
                end
              end else if (state == S_PTR) begin
                ptr_o    <= sh;
                state    <= S_PACK;
                sda_oe_o <= 1'b1;
              end else begin
                wr_en_o  <= 1'b1;
                state    <= S_WACK;
                sda_oe_o <= 1'b1;
              end
            end
          end
          S_AACK, S_PACK: begin
            if (scl_fall_i) begin
              bitcnt <= '0;
              if (state == S_AACK && rd_mode) begin
                state    <= S_RDAT;
                sh       <= rd_data_i;
                sda_oe_o <= ~rd_data_i[7];
              end else begin
                state    <= (state == S_AACK) ? S_PTR : S_WDAT;
                sda_oe_o <= 1'b0;
              end
            end
          end
          S_WACK: begin
            if (scl_fall_i) begin
              state    <= S_IGN;
              sda_oe_o <= 1'b0;
            end
          end
          S_RDAT: begin
            if (scl_rise_i) begin
              bitcnt <= bitcnt + 1'b1;
            end else if (scl_fall_i) begin
              if (bitcnt == 4'd8) begin
                state    <= S_MACK;
                sda_oe_o <= 1'b0;
              end else begin
                sh       <= {sh[6:0], 1'b0};
                sda_oe_o <= ~sh[6];
              end
            end
          end
          S_MACK: if (scl_rise_i) state <= S_IGN;
          default: ;
        endcase
      end
    end
  end

  AST_OE_SCL_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sda_oe_o) |-> !scl_s_i); // R2
  AST_IGN_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == S_IGN) |-> !sda_oe_o); // R10
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == S_IDLE) |-> !sda_oe_o); // R3
  AST_WR_AFTER_ACKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |-> (state == S_WACK) && sda_oe_o); // R4
endmodule

// File: rtl/smb_regfile.sv
module smb_regfile
  import smb_cfg_pkg::*;
#(
  parameter int NUM_CH = 2
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   hold_i,
  input  logic                   wr_en_i,
  input  logic [7:0]             ptr_i,
  input  logic [7:0]             wr_data_i,
  output logic [7:0]             rd_data_o,
  output logic [7:0]             ovr_o,
  output logic                   mst_rst_o,
  output logic [NUM_CH-1:0][7:0] ch_eq_o,
  output logic [NUM_CH-1:0][2:0] ch_dem_o,
  output logic [NUM_CH-1:0]      ch_rate_o,
  output logic [NUM_CH-1:0][1:0] ch_rxd_o,
  output logic [NUM_CH-1:0][3:0] ch_idle_o
);
  localparam int NSLOT = GLB_SLOTS + CH_FIELDS * NUM_CH;

  logic [7:0] q [NSLOT];
  logic       glb_rst;

  assign glb_rst = q[0][CTRL_RST];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < NSLOT; s++) q[s] <= slot_def(s);
    end else begin
      for (int s = 0; s < NSLOT; s++) begin
        if (hold_i || glb_rst)
          q[s] <= slot_def(s);
        else if (wr_en_i && ptr_i == slot_addr(s))
          q[s] <= (q[s] & ~slot_mask(s)) | (wr_data_i & slot_mask(s));
        else if (s == 0)
          q[s][CTRL_MST] <= 1'b0;
      end
    end
  end

  always_comb begin
    rd_data_o = '0;
    for (int s = 0; s < NSLOT; s++)
      if (ptr_i == slot_addr(s)) rd_data_o = q[s];
  end

  assign ovr_o     = q[1];
  assign mst_rst_o = q[0][CTRL_MST];

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    localparam int B = GLB_SLOTS + CH_FIELDS * c;
    assign ch_eq_o[c]   = q[B + F_EQ];
    assign ch_dem_o[c]  = q[B + F_DEM][2:0];
    assign ch_rate_o[c] = q[B + F_RATE][6];
    assign ch_rxd_o[c]  = q[B + F_RXD][3:2];
    assign ch_idle_o[c] = q[B + F_IDLE][3:0];
  end

  for (genvar s = 0; s < NSLOT; s++) begin : g_hold_chk
    AST_HOLD_DEFAULT: assert property (@(posedge clk_i) disable iff (!rst_ni)
      hold_i |=> (q[s] == slot_def(s))); // R6
  end

  AST_RST_SELF_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    glb_rst |=> !glb_rst); // R8
  AST_MST_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mst_rst_o |=> !mst_rst_o); // R8
  AST_INFO_RO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    q[2] == 8'h77); // R9
endmodule

// File: rtl/smb_cfg_slave.sv
module smb_cfg_slave
  import smb_cfg_pkg::*;
#(
  parameter int NUM_CH   = 2,
  parameter int TBUF_CYC = 50
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   scl_i,
  input  logic                   sda_i,
  output logic                   sda_oe_o,
  input  logic [3:0]             strap_i,
  input  logic                   mode_i,
  input  logic [NUM_CH-1:0][7:0] eq_pin_i,
  input  logic [NUM_CH-1:0][2:0] dem_pin_i,
  input  logic                   rate_pin_i,
  input  logic [1:0]             rxdet_pin_i,
  input  logic [3:0]             idle_pin_i,
  output logic [NUM_CH-1:0][7:0] eq_o,
  output logic [NUM_CH-1:0][2:0] dem_o,
  output logic [NUM_CH-1:0]      rate_o,
  output logic [NUM_CH-1:0][1:0] rxdet_o,
  output logic [NUM_CH-1:0][3:0] idle_o,
  output logic                   mst_rst_o
);
  logic scl_s, sda_s, scl_rise, scl_fall, start, stop, free;
  logic wr_en;
  logic [7:0] ptr, wr_data, rd_data, ovr;
  logic [NUM_CH-1:0][7:0] r_eq;
  logic [NUM_CH-1:0][2:0] r_dem;
  logic [NUM_CH-1:0]      r_rate;
  logic [NUM_CH-1:0][1:0] r_rxd;
  logic [NUM_CH-1:0][3:0] r_idle;

  smb_bus_mon #(.TBUF_CYC(TBUF_CYC)) u_mon (
    .clk_i, .rst_ni, .scl_i, .sda_i,
    .scl_s_o(scl_s), .sda_s_o(sda_s), .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
    .start_o(start), .stop_o(stop), .free_o(free)
  );

  smb_proto u_proto (
    .clk_i, .rst_ni,
    .scl_s_i(scl_s), .sda_s_i(sda_s), .scl_rise_i(scl_rise), .scl_fall_i(scl_fall),
    .start_i(start), .stop_i(stop), .free_i(free), .strap_i,
    .rd_data_i(rd_data), .sda_oe_o, .wr_en_o(wr_en), .ptr_o(ptr), .wr_data_o(wr_data)
  );

  smb_regfile #(.NUM_CH(NUM_CH)) u_regs (
    .clk_i, .rst_ni, .hold_i(~mode_i),
    .wr_en_i(wr_en), .ptr_i(ptr), .wr_data_i(wr_data), .rd_data_o(rd_data),
    .ovr_o(ovr), .mst_rst_o,
    .ch_eq_o(r_eq), .ch_dem_o(r_dem), .ch_rate_o(r_rate), .ch_rxd_o(r_rxd), .ch_idle_o(r_idle)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_sel
    assign eq_o[c]    = mode_i ? r_eq[c]  : eq_pin_i[c];
    assign dem_o[c]   = mode_i ? r_dem[c] : dem_pin_i[c];
    assign rate_o[c]  = (mode_i && ovr[OVR_RATE]) ? r_rate[c] : rate_pin_i;
    assign rxdet_o[c] = (mode_i && ovr[OVR_RXD])  ? r_rxd[c]  : rxdet_pin_i;
    assign idle_o[c]  = (mode_i && ovr[OVR_IDLE]) ? r_idle[c] : idle_pin_i;
  end

  AST_PIN_MODE_EQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mode_i |-> (eq_o == eq_pin_i) && (dem_o == dem_pin_i)); // R6
  AST_NO_OVR_PINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mode_i |-> (rate_o == {NUM_CH{rate_pin_i}})); // R7
endmodule

// File: tb/smb_cfg_slave_tb.sv
module smb_cfg_slave_tb;
  localparam int NCH  = 2;
  localparam int TBUF = 20;
  localparam int Q    = 5;
  localparam int GAP  = 30;
  localparam int NSL  = 3 + 5 * NCH;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n = 1'b0;
  logic scl_drv = 1'b1, sda_drv = 1'b1;
  logic sda_oe, mode, rate_pin, mst_rst;
  logic [3:0] strap, idle_pin;
  logic [1:0] rxdet_pin;
  logic [NCH-1:0][7:0] eq_pin, eq_o;
  logic [NCH-1:0][2:0] dem_pin, dem_o;
  logic [NCH-1:0] rate_o;
  logic [NCH-1:0][1:0] rxdet_o;
  logic [NCH-1:0][3:0] idle_o;
  logic sda_bus;
  assign sda_bus = sda_drv & ~sda_oe;

  smb_cfg_slave #(.NUM_CH(NCH), .TBUF_CYC(TBUF)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl_drv), .sda_i(sda_bus), .sda_oe_o(sda_oe),
    .strap_i(strap), .mode_i(mode), .eq_pin_i(eq_pin), .dem_pin_i(dem_pin),
    .rate_pin_i(rate_pin), .rxdet_pin_i(rxdet_pin), .idle_pin_i(idle_pin),
    .eq_o(eq_o), .dem_o(dem_o), .rate_o(rate_o), .rxdet_o(rxdet_o), .idle_o(idle_o),
    .mst_rst_o(mst_rst)
  );

  int n_chk = 0, n_err = 0, mst_cnt = 0, oe_viol = 0;
  bit done = 1'b0;
  logic oe_prev = 1'b0;

  always @(posedge clk) begin
    if (mst_rst) mst_cnt++;
    if (sda_oe !== oe_prev && scl_drv) oe_viol++;
    oe_prev <= sda_oe;
  end

  // expected register map (from the requirements)
  function automatic logic [7:0] m_addr(int i);
    if (i == 0) return 8'h07;
    if (i == 1) return 8'h08;
    if (i == 2) return 8'h51;
    return 8'(8'h0E + 7 * ((i - 3) / 5) + (i - 3) % 5);
  endfunction
  function automatic logic [7:0] m_def(int i);
    logic [7:0] t [5] = '{8'h00, 8'h2F, 8'hED, 8'h02, 8'h00};
    if (i == 0) return 8'h01;
    if (i == 1) return 8'h00;
    if (i == 2) return 8'h77;
    return t[(i - 3) % 5];
  endfunction
  function automatic logic [7:0] m_mask(int i);
    logic [7:0] t [5] = '{8'h0C, 8'hFF, 8'hC0, 8'h07, 8'h0F};
    if (i == 0) return 8'h60;
    if (i == 1) return 8'h4C;
    if (i == 2) return 8'h00;
    return t[(i - 3) % 5];
  endfunction

  task automatic chk(string req, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic wq(int n); repeat (n) @(negedge clk); endtask

  task automatic b_start; sda_drv = 1; scl_drv = 1; wq(Q); sda_drv = 0; wq(Q); scl_drv = 0; wq(Q); endtask
  task automatic b_rstart; sda_drv = 1; wq(Q); scl_drv = 1; wq(Q); sda_drv = 0; wq(Q); scl_drv = 0; wq(Q); endtask
  task automatic b_stop; sda_drv = 0; wq(Q); scl_drv = 1; wq(Q); sda_drv = 1; wq(Q); endtask
  task automatic b_wbit(bit b); sda_drv = b; wq(Q); scl_drv = 1; wq(2 * Q); scl_drv = 0; wq(Q); endtask
  task automatic b_rbit(output bit b);
    sda_drv = 1; wq(Q); scl_drv = 1; wq(Q); b = sda_bus; wq(Q); scl_drv = 0; wq(Q);
  endtask
  task automatic b_wbyte(input logic [7:0] v, output bit ack);
    bit a;
    for (int i = 7; i >= 0; i--) b_wbit(v[i]);
    b_rbit(a);
    ack = ~a;
  endtask
  task automatic b_rbyte(output logic [7:0] v);
    bit a;
    for (int i = 7; i >= 0; i--) begin b_rbit(a); v[i] = a; end
    b_wbit(1'b1); // master NACK
  endtask

  function automatic logic [7:0] abyte(bit rd);
    return {7'(7'h58 + 7'(strap)), rd};
  endfunction

  task automatic wr_reg(input logic [7:0] p, input logic [7:0] v, output bit ok);
    bit a0, a1, a2;
    b_start; b_wbyte(abyte(0), a0); b_wbyte(p, a1); b_wbyte(v, a2); b_stop; wq(GAP);
    ok = a0 & a1 & a2;
  endtask
  task automatic rd_reg(input logic [7:0] p, output logic [7:0] v, output bit ok);
    bit a0, a1, a2;
    b_start; b_wbyte(abyte(0), a0); b_wbyte(p, a1);
    b_rstart; b_wbyte(abyte(1), a2); b_rbyte(v); b_stop; wq(GAP);
    ok = a0 & a1 & a2;
  endtask

  task automatic summary;
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog run did not finish actual=0 expected=1");
      summary;
      $finish;
    end
  end

  initial begin
    logic [7:0] rv, ex;
    bit ok, ack;
    int c0;
    logic [7:0] pats [3] = '{8'hFF, 8'h00, 8'hA5};
    mode = 0; strap = 4'h0; rate_pin = 1; rxdet_pin = 2'b01; idle_pin = 4'h9;
    eq_pin = {8'hC3, 8'h3C}; dem_pin = {3'd5, 3'd6};
    wq(5); rst_n = 1; wq(5);

    // R6 pin mode after reset
    chk("R6", "eq_o[0] pin mode", eq_o[0], 8'h3C);
    chk("R6", "eq_o[1] pin mode", eq_o[1], 8'hC3);
    chk("R6", "dem_o[0] pin mode", dem_o[0], 3'd6);
    mode = 1; wq(1);
    chk("R6", "eq_o[0] register mode", eq_o[0], 8'h2F);
    chk("R6", "dem_o[1] register mode", dem_o[1], 3'd2);

    // R11 defaults, R5 read path
    for (int i = 0; i < NSL; i++) begin
      rd_reg(m_addr(i), rv, ok);
      chk("R5", "read acks", ok, 1);
      chk("R11", $sformatf("default @%0h", m_addr(i)), rv, m_def(i));
    end
    rd_reg(8'h00, rv, ok);
    chk("R5", "unmapped read", rv, 8'h00);

    // R1 strap sweep
    for (int s = 0; s < 16; s++) begin
      strap = 4'(s); wq(2);
      b_start; b_wbyte({7'(7'h58 + s), 1'b0}, ack); b_stop; wq(GAP);
      chk("R1", $sformatf("own address strap %0d", s), ack, 1);
      b_start; b_wbyte({7'(7'h58 + ((s + 1) % 16)), 1'b0}, ack); b_stop; wq(GAP);
      chk("R1", $sformatf("neighbour address strap %0d", s), ack, 0);
    end
    strap = 4'h3; wq(2);

    // R4 / R9 write-mask sweep
    for (int k = 0; k < 3; k++) begin
      for (int i = 1; i < NSL; i++) begin
        wr_reg(m_addr(i), pats[k], ok);
        chk("R4", "write acks", ok, 1);
        rd_reg(m_addr(i), rv, ok);
        ex = (m_def(i) & ~m_mask(i)) | (pats[k] & m_mask(i));
        chk("R9", $sformatf("masked write @%0h", m_addr(i)), rv, ex);
        if (i == 4) chk("R6", "eq_o[0] follows register", eq_o[0], pats[k]);
      end
    end

    // R8 global reset and master pulse
    wr_reg(8'h07, 8'h40, ok);
    rd_reg(8'h0F, rv, ok); chk("R8", "eq restored", rv, 8'h2F);
    rd_reg(8'h08, rv, ok); chk("R8", "override restored", rv, 8'h00);
    rd_reg(8'h07, rv, ok); chk("R8", "reset bit cleared", rv, 8'h01);
    c0 = mst_cnt;
    wr_reg(8'h07, 8'h20, ok);
    chk("R8", "master reset pulse length", mst_cnt - c0, 1);
    rd_reg(8'h07, rv, ok); chk("R8", "master bit cleared", rv, 8'h01);

    // R6 pin mode holds defaults, ignores writes
    wr_reg(8'h0F, 8'h5A, ok);
    chk("R6", "eq_o[0] register value", eq_o[0], 8'h5A);
    mode = 0; wq(3);
    chk("R6", "eq_o[0] back to pin", eq_o[0], 8'h3C);
    wr_reg(8'h0F, 8'h33, ok);
    mode = 1; wq(1);
    chk("R6", "eq_o[0] default after pin mode", eq_o[0], 8'h2F);

    // R7 overrides
    wr_reg(8'h10, 8'h00, ok);
    wr_reg(8'h0E, 8'h0C, ok);
    wr_reg(8'h12, 8'h06, ok);
    chk("R7", "rate_o[0] pin without override", rate_o[0], 1);
    chk("R7", "rxdet_o[0] pin without override", rxdet_o[0], 2'b01);
    wr_reg(8'h08, 8'h04, ok);
    chk("R7", "rate_o[0] from register", rate_o[0], 0);
    chk("R7", "rate_o[1] from register default", rate_o[1], 1);
    chk("R7", "rxdet_o[0] still pin", rxdet_o[0], 2'b01);
    chk("R7", "idle_o[0] still pin", idle_o[0], 4'h9);
    wr_reg(8'h08, 8'h4C, ok);
    chk("R7", "rxdet_o[0] from register", rxdet_o[0], 2'b11);
    chk("R7", "idle_o[0] from register", idle_o[0], 4'h6);
    chk("R7", "idle_o[1] from register", idle_o[1], 4'h0);

    // R3 bus-free time
    b_start; b_wbyte(abyte(0), ack); b_wbyte(8'h0F, ack); b_stop;
    b_start; b_wbyte(abyte(0), ack); b_stop; wq(GAP);
    chk("R3", "START too soon after STOP", ack, 0);
    rd_reg(8'h0F, rv, ok);
    chk("R3", "accepted after bus free", ok, 1);

    // R10 mismatch ignores following bytes
    wr_reg(8'h0F, 8'h77, ok);
    b_start;
    b_wbyte({7'(7'h58 + 4), 1'b0}, ack); chk("R10", "mismatch address", ack, 0);
    b_wbyte(8'h0F, ack); chk("R10", "pointer after mismatch", ack, 0);
    b_wbyte(8'h99, ack); chk("R10", "data after mismatch", ack, 0);
    b_stop; wq(GAP);
    rd_reg(8'h0F, rv, ok); chk("R10", "register unchanged", rv, 8'h77);

    // R5 MSB-first read with NACK end
    rd_reg(8'h51, rv, ok); chk("R5", "identity byte", rv, 8'h77);
    chk("R5", "SDA released after NACK", sda_oe, 0);
    chk("R2", "slave SDA changes while SCL high", oe_viol, 0);

    done = 1'b1;
    summary;
    $finish;
  end
endmodule